// File: doc/BRIEF.md
# Triangle-Wave Frequency Dither Generator

This block produces a digital offset that a downstream digitally controlled oscillator subtracts from its nominal frequency word, spreading the oscillator's energy over a narrow band just below nominal. The offset follows a symmetric triangle. It climbs from zero to a peak depth and falls back to zero. The peak depth is a selected percentage of the nominal word, and the repetition period is a fixed number of master clocks picked by a rate code. Because the offset is never negative, the instantaneous frequency stays between nominal and nominal minus the selected depth.

The sweep state changes only at a trough. At a trough the block samples the spread enable, the depth and rate codes and the nominal word. It then either starts the next period with those settings or parks at zero. Any change therefore takes effect with no step in the offset. A one-cycle flag marks each trough and each peak, so the downstream logic or a bench can measure the period directly.

Top module: `tri_dither_gen`

## Requirements
- R1: The peak offset is floor(nom_word × K / 65536), where K = 328 for depth code 000, 655 for 001, 1311 for 010, 2621 for 100 and 5243 for 111.
- R2: One period lasts 8192 clocks for rate code 00, 4096 for 01 and 2048 for 10. Rate code 11 is reserved and is treated as a request to stay idle.
- R3: With half period H = period/2 and phase k counted from the trough (k = 0 .. 2H-1), the offset is floor(peak × p / H), where p = k for k ≤ H and p = 2H - k otherwise. The offset is never negative and never exceeds the peak.
- R4: While idle, offset_o is 0 and neither flag pulses. The block stays idle while spread_en is low.
- R5: If spread_en is low at the last cycle of a period, the running sweep finishes its period and the offset is then held at 0. Lowering spread_en mid-period does not cut the sweep short.
- R6: A reserved depth code (011, 101, 110) seen at a trough, or at a start, ends or prevents the sweep, so the offset stays 0.
- R7: Depth, rate and nominal word are sampled only when a sweep starts or when a period ends. Changes made mid-period do not alter the current period.
- R8: trough_o is high for exactly the phase-0 cycle and peak_o for exactly the phase-H cycle of each running period. The two flags are never high together.
- R9: After reset the block is idle: offset_o is 0 and both flags are low.
- R10: From idle, the first clock edge that sees a valid request (spread_en high, valid depth code, valid rate code) starts a sweep. The next cycle is a trough with trough_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | Request to dither |
| depth_sel | input | 3 | Depth percentage code |
| rate_sel | input | 2 | Period select code |
| nom_word | input | NOM_W | Nominal oscillator frequency word |
| offset_o | output | NOM_W | Non-negative amount to subtract from the nominal word |
| peak_o | output | 1 | One-cycle pulse at maximum offset |
| trough_o | output | 1 | One-cycle pulse at zero-offset phase |

## Verification
The interesting collision happens at the last cycle of a period. At that edge the stop decision for a falling spread_en and the reload of new depth or rate settings both fall due. The bench provokes it by counting from an observed trough pulse to the final phase cycle. At that cycle it lowers spread_en and changes the depth code together. It then confirms that the block parks with no trough pulse and zero offset. On re-enable, the new depth shows up in the next peak value. A behavioural model computes every expected offset and flag from the formulas in the requirements and is compared every cycle.

// File: rtl/tri_dither_gen.sv
module tri_dither_gen #(
  parameter int NOM_W  = 24,
  parameter int KFRAC  = 16,
  parameter int HB_MAX = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spread_en,
  input  logic [2:0]       depth_sel,
  input  logic [1:0]       rate_sel,
  input  logic [NOM_W-1:0] nom_word,
  output logic [NOM_W-1:0] offset_o,
  output logic             peak_o,
  output logic             trough_o
);

  localparam int ACC_W  = NOM_W + HB_MAX;
  localparam int PH_W   = HB_MAX + 1;
  localparam int SH_W   = $clog2(HB_MAX + 1);
  localparam int PROD_W = NOM_W + KFRAC;
  localparam int K_HALF = ((1 << KFRAC) * 5 + 500) / 1000;
  localparam int K_1    = ((1 << KFRAC) * 10 + 500) / 1000;
  localparam int K_2    = ((1 << KFRAC) * 20 + 500) / 1000;
  localparam int K_4    = ((1 << KFRAC) * 40 + 500) / 1000;
  localparam int K_8    = ((1 << KFRAC) * 80 + 500) / 1000;

  logic             run;
  logic [PH_W-1:0]  ph;
  logic [ACC_W-1:0] acc;
  logic [NOM_W-1:0] peak_q;
  logic [SH_W-1:0]  hsh_q;

  logic [KFRAC-1:0]  k_sel;
  logic              depth_ok;
  logic              req;
  logic [PROD_W-1:0] prod;
  logic [NOM_W-1:0]  new_peak;
  logic [SH_W-1:0]   new_hsh;
  logic [PH_W-1:0]   half;
  logic [PH_W-1:0]   last;
  logic              at_end;

  always_comb begin
    depth_ok = 1'b1;
    case (depth_sel)
      3'b000:  k_sel = KFRAC'(K_HALF);
      3'b001:  k_sel = KFRAC'(K_1);
      3'b010:  k_sel = KFRAC'(K_2);
      3'b100:  k_sel = KFRAC'(K_4);
      3'b111:  k_sel = KFRAC'(K_8);
      default: begin
        k_sel    = '0;
        depth_ok = 1'b0;
      end
    endcase
  end

  assign req      = spread_en && depth_ok && (rate_sel != 2'b11);
  assign prod     = PROD_W'(nom_word) * PROD_W'(k_sel);
  assign new_peak = NOM_W'(prod >> KFRAC);
  assign new_hsh  = SH_W'(HB_MAX) - {{(SH_W-2){1'b0}}, rate_sel};
  assign half     = PH_W'(1) << hsh_q;
  assign last     = PH_W'((half << 1) - PH_W'(1));
  assign at_end   = (ph == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      ph     <= '0;
      acc    <= '0;
      peak_q <= '0;
      hsh_q  <= SH_W'(HB_MAX);
    end else if (!run) begin
      if (req) begin
        run    <= 1'b1;
        peak_q <= new_peak;
        hsh_q  <= new_hsh;
      end
    end else if (at_end) begin
      ph  <= '0;
      acc <= '0;
      run <= req;
      if (req) begin
        peak_q <= new_peak;
        hsh_q  <= new_hsh;
      end
    end else begin
      ph  <= ph + PH_W'(1);
      acc <= (ph < half) ? acc + ACC_W'(peak_q) : acc - ACC_W'(peak_q);
    end
  end

  assign offset_o = NOM_W'(acc >> hsh_q);
  assign peak_o   = run && (ph == half);
  assign trough_o = run && (ph == '0);

  // R3
  offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset_o <= peak_q);

  // R3
  rise_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ph < half) |=> (offset_o >= $past(offset_o)));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(peak_o && trough_o));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (offset_o == '0 && !peak_o && !trough_o));

  // R5
  stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end) |=> run);

  // R7
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end) |=> ($stable(peak_q) && $stable(hsh_q)));

endmodule

// File: tb/tri_dither_gen_bench.sv
module tri_dither_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 24;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          spread_en = 1'b0;
  logic [2:0]    depth_sel = 3'b000;
  logic [1:0]    rate_sel = 2'b10;
  logic [NW-1:0] nom_word = NW'(1000000);
  logic [NW-1:0] offset_o;
  logic          peak_o;
  logic          trough_o;

  tri_dither_gen u_tri_dither_gen (
    .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .depth_sel(depth_sel),
    .rate_sel(rate_sel), .nom_word(nom_word), .offset_o(offset_o),
    .peak_o(peak_o), .trough_o(trough_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_tag = "R9";

  bit     m_run = 0;
  int     m_ph = 0;
  int     m_h = 4096;
  longint m_peak = 0;

  function automatic longint kval(logic [2:0] d);
    case (d)
      3'b000: return 328;
      3'b001: return 655;
      3'b010: return 1311;
      3'b100: return 2621;
      3'b111: return 5243;
      default: return -1;
    endcase
  endfunction

  function automatic bit mreq();
    return spread_en && (kval(depth_sel) >= 0) && (rate_sel != 2'b11);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void mload();
    m_peak = (longint'(nom_word) * kval(depth_sel)) >> 16;
    m_h = 1 << (12 - int'(rate_sel));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_ph = 0; m_peak = 0;
    end else if (!m_run) begin
      if (mreq()) begin
        m_run = 1; m_ph = 0; mload();
      end
    end else if (m_ph == 2*m_h - 1) begin
      m_ph = 0;
      m_run = mreq();
      if (m_run) mload();
    end else begin
      m_ph++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      longint p;
      longint e_off;
      p = (m_ph <= m_h) ? m_ph : 2*m_h - m_ph;
      e_off = m_run ? (m_peak * p) / m_h : 0;
      chk(cur_tag, offset_o, e_off);
      chk("R8 trough_o", trough_o, (m_run && m_ph == 0) ? 1 : 0);
      chk("R8 peak_o", peak_o, (m_run && m_ph == m_h) ? 1 : 0);
      if (cyc > WATCHDOG) begin
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic wait_flag(bit want_peak);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_peak ? peak_o : trough_o) && n < 20000);
    if (n >= 20000) chk("R8 flag timeout", 0, 1);
  endtask

  task automatic peak_check(string tag, longint nom, logic [2:0] d);
    wait_flag(1);
    chk(tag, offset_o, (nom * kval(d)) >> 16);
  endtask

  task automatic period_check(string tag, int exp);
    int n = 0;
    wait_flag(0);
    do begin
      @(negedge clk);
      n++;
    end while (!trough_o && n < 20000);
    chk(tag, n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs idle during reset
    chk("R9 offset", offset_o, 0);
    chk("R9 flags", peak_o | trough_o, 0);
    rst_n = 1'b1;
    cur_tag = "R4";
    repeat (20) @(negedge clk);
    chk("R4 idle offset", offset_o, 0);

    // R10: start from idle
    cur_tag = "R10";
    spread_en = 1'b1;
    @(negedge clk);
    chk("R10 first trough", trough_o, 1);

    // R1: every valid depth code, rate 10
    cur_tag = "R3";
    begin
      logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b111};
      foreach (codes[i]) begin
        depth_sel = codes[i];
        wait_flag(0);
        peak_check("R1 peak", 1000000, codes[i]);
      end
    end

    // R2: periods for each rate
    rate_sel = 2'b00;
    wait_flag(0);
    period_check("R2 period 00", 8192);
    rate_sel = 2'b01;
    wait_flag(0);
    period_check("R2 period 01", 4096);
    rate_sel = 2'b10;
    wait_flag(0);
    period_check("R2 period 10", 2048);

    // R7: nominal change mid-period applies only at the next trough
    cur_tag = "R7";
    depth_sel = 3'b111;
    wait_flag(0);
    wait_flag(0);
    repeat (300) @(negedge clk);
    nom_word = NW'(3000000);
    peak_check("R7 old nominal", 1000000, 3'b111);
    peak_check("R7 new nominal", 3000000, 3'b111);

    // R6: reserved depth code stops the sweep at the trough
    cur_tag = "R6";
    depth_sel = 3'b011;
    repeat (2100) @(negedge clk);
    chk("R6 reserved depth offset", offset_o, 0);
    chk("R6 no trough", trough_o, 0);
    depth_sel = 3'b010;
    @(negedge clk);
    chk("R6 restart trough", trough_o, 1);

    // R2: reserved rate code keeps the block idle
    rate_sel = 2'b11;
    repeat (2100) @(negedge clk);
    chk("R2 reserved rate offset", offset_o, 0);
    rate_sel = 2'b10;

    // R5: dropping enable mid-sweep finishes the period
    cur_tag = "R5";
    wait_flag(1);
    spread_en = 1'b0;
    @(negedge clk);
    chk("R5 still sweeping", offset_o != 0, 1);
    repeat (1100) @(negedge clk);
    chk("R5 parked offset", offset_o, 0);

    // R5 + R7: enable drop and depth change on the final phase cycle
    spread_en = 1'b1;
    depth_sel = 3'b111;
    wait_flag(0);
    repeat (2047) @(negedge clk);
    spread_en = 1'b0;
    depth_sel = 3'b001;
    @(negedge clk);
    chk("R5 no trough after stop", trough_o, 0);
    chk("R5 zero after stop", offset_o, 0);
    spread_en = 1'b1;
    @(negedge clk);
    chk("R10 restart trough", trough_o, 1);
    peak_check("R1 peak after collision", 3000000, 3'b001);

    repeat (10) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule